// File: doc/BRIEF.md
# Alarm Onset Interrupt Status Register

This block captures the moment each of six continuous receive alarms begins on a DS3/E3 line receiver and holds that event until software reads it. The six alarms are out-of-frame, alarm indication signal, remote alarm indication (yellow), idle, loss of signal and severely errored frame. Each alarm arrives as a level. The block registers every level once and latches a status bit only on a 0-to-1 transition, so an alarm that stays up is reported once.

A read strobe returns the 8-bit status word and clears every latched bit. An interrupt request is formed from the latched bits that are enabled, and it is registered. When an event's enable goes from 0 to 1, that event's bit is wiped so a stale event cannot raise an interrupt at once. In E3 mode the severely errored frame and idle events have no meaning, so their bits are held at zero. The loss-of-signal input is expected to come from a detector that watches the line before B3ZS/HDB3 decoding.

Top module: `alarm_onset_status`

## Requirements
- R1: The read word places out-of-frame at bit 0, alarm indication signal at bit 1, yellow at bit 2, idle at bit 3, loss of signal at bit 4 and severely errored frame at bit 5; bits 7 and 6 always read 0.
- R2: After reset the read word is 0x00 and the interrupt request is low.
- R3: A cycle with the read strobe high returns the current latched word on the read data, and every latched bit is cleared at the clock edge that ends that cycle.
- R4: A status bit is set at the clock edge after its alarm level is first sampled high following a low sample; a level that stays high sets the bit only once.
- R5: When an event's enable is sampled 1 after being 0, that event's latched bit is cleared at that edge; bits of other events are unaffected.
- R6: While E3 mode is selected (mode input 1), bits 5 and 3 stay 0 even when their alarm levels rise.
- R7: An onset in the same cycle as a clearing read wins: the bit is set after the edge, and the read returns the value from before the edge.
- R8: An onset in the same cycle as that event's enable rising edge wins: the bit is set after the edge.
- R9: The interrupt request is a register equal to the OR, over the six events, of each latched bit ANDed with its enable. It falls in the cycle after a clearing read, and an event whose enable is 0 does not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| alarmLvl | input | 6 | Continuous alarm levels, ordered as the status bits |
| e3Mode | input | 1 | 1 selects E3 mode, 0 selects DS3 mode |
| evtEnable | input | 6 | Per-event interrupt enable, ordered as the status bits |
| rdStrobe | input | 1 | Register read strobe, one cycle per read |
| rdData | output | 8 | Status word; bits 7:6 are zero |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can land on one edge. The first is a new alarm onset arriving in the cycle of a clearing read. The second is an onset arriving in the cycle where that event's enable rises. The bench drives the alarm rising edge together with the read strobe, or together with the enable edge. It then reads the word in that cycle and again in the next one. It expects the pre-edge value first and the set bit afterwards, with the interrupt following the enable.

// File: rtl/alarm_onset_pkg.sv
package alarm_onset_pkg;
  localparam int EVT_N = 6;
  localparam int REG_W = 8;
  localparam int PAD_W = REG_W - EVT_N;

  // bit positions of each event in the status word
  localparam int BIT_OOF  = 0;
  localparam int BIT_AIS  = 1;
  localparam int BIT_YEL  = 2;
  localparam int BIT_IDLE = 3;
  localparam int BIT_LOS  = 4;
  localparam int BIT_SEF  = 5;

  typedef struct packed {
    logic             readClr;
    logic [EVT_N-1:0] enRise;
    logic [EVT_N-1:0] keepMask;
  } ctlStrobes_t;
endpackage

// File: rtl/onset_ctrl.sv
module onset_ctrl
  import alarm_onset_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             e3Mode,
  input  logic [EVT_N-1:0] evtEnable,
  input  logic             rdStrobe,
  output ctlStrobes_t      strobes
);
  logic [EVT_N-1:0] enPrev;
  logic [EVT_N-1:0] keep;

  always_ff @(posedge clk) begin
    if (!rstN) enPrev <= '0;
    else       enPrev <= evtEnable;
  end

  // events undefined in E3 are suppressed
  always_comb begin
    keep = '1;
    if (e3Mode) begin
      keep[BIT_SEF]  = 1'b0;
      keep[BIT_IDLE] = 1'b0;
    end
  end

  always_comb begin
    strobes.readClr  = rdStrobe;
    strobes.enRise   = evtEnable & ~enPrev;
    strobes.keepMask = keep;
  end
endmodule

// File: rtl/onset_datapath.sv
module onset_datapath
  import alarm_onset_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_N-1:0] alarmLvl,
  input  logic [EVT_N-1:0] evtEnable,
  input  ctlStrobes_t      strobes,
  output logic [EVT_N-1:0] statusQ,
  output logic             irqQ
);
  logic [EVT_N-1:0] prevLvl;
  logic [EVT_N-1:0] statusD;

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= alarmLvl;
  end

  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    logic onset;
    logic wipe;
    always_comb begin
      onset      = alarmLvl[i] & ~prevLvl[i];
      wipe       = strobes.readClr | strobes.enRise[i];
      // a fresh onset outranks any clear in the same cycle
      statusD[i] = ((statusQ[i] & ~wipe) | onset) & strobes.keepMask[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusD;
      irqQ    <= |(statusD & evtEnable);
    end
  end
endmodule

// File: rtl/alarm_onset_status.sv
module alarm_onset_status
  import alarm_onset_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_N-1:0] alarmLvl,
  input  logic             e3Mode,
  input  logic [EVT_N-1:0] evtEnable,
  input  logic             rdStrobe,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  ctlStrobes_t      strobes;
  logic [EVT_N-1:0] statusQ;

  onset_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .e3Mode    (e3Mode),
    .evtEnable (evtEnable),
    .rdStrobe  (rdStrobe),
    .strobes   (strobes)
  );

  onset_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .alarmLvl  (alarmLvl),
    .evtEnable (evtEnable),
    .strobes   (strobes),
    .statusQ   (statusQ),
    .irqQ      (irq)
  );

  assign rdData = {{PAD_W{1'b0}}, statusQ};
endmodule

// File: rtl/alarm_onset_chk.sv
module alarm_onset_chk
  import alarm_onset_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [EVT_N-1:0] alarmLvl,
  input logic             e3Mode,
  input logic [EVT_N-1:0] evtEnable,
  input logic             rdStrobe,
  input logic [REG_W-1:0] rdData,
  input logic             irq
);
  // R4: a bit can only appear after its level was high
  a_r4_set_needs_level: assert property (@(posedge clk) disable iff (!rstN)
    ((rdData[EVT_N-1:0] & ~$past(rdData[EVT_N-1:0]) & ~$past(alarmLvl)) == '0));

  // R3: after a read only bits with a fresh level may remain
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdStrobe) |-> ((rdData[EVT_N-1:0] & ~$past(alarmLvl)) == '0));

  // R5: enable rising edge wipes the bit unless an onset competes
  a_r5_enable_wipe: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(evtEnable) & ~$past(evtEnable, 2)) & rdData[EVT_N-1:0]
      & ~$past(alarmLvl)) == '0));

  // R6: E3 mode keeps the SEF and idle bits low
  a_r6_e3_bits_low: assert property (@(posedge clk) disable iff (!rstN)
    $past(e3Mode) |-> (!rdData[BIT_SEF] && !rdData[BIT_IDLE]));

  // R9: request tracks latched-and-enabled bits one edge later
  a_r9_irq_match: assert property (@(posedge clk) disable iff (!rstN)
    irq == |(rdData[EVT_N-1:0] & $past(evtEnable)));
endmodule

bind alarm_onset_status alarm_onset_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .alarmLvl  (alarmLvl),
  .e3Mode    (e3Mode),
  .evtEnable (evtEnable),
  .rdStrobe  (rdStrobe),
  .rdData    (rdData),
  .irq       (irq)
);

// File: tb/sim_alarm_onset_status.sv
module sim_alarm_onset_status;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 24;
  // row: alarm[22:17] e3[16] en[15:10] rd[9] expPreRd[8:1] expPreIrq[0]
  localparam logic [22:0] VEC [ROWS] = '{
    {6'h00, 1'b0, 6'h3F, 1'b0, 8'h00, 1'b0}, // 0  R2 start clean
    {6'h01, 1'b0, 6'h3F, 1'b0, 8'h00, 1'b0}, // 1  OOF rises
    {6'h01, 1'b0, 6'h3F, 1'b0, 8'h01, 1'b1}, // 2  R1 bit0, R4 R9
    {6'h01, 1'b0, 6'h3F, 1'b1, 8'h01, 1'b1}, // 3  R3 read returns pre value
    {6'h01, 1'b0, 6'h3F, 1'b0, 8'h00, 1'b0}, // 4  R4 held level no re-set, R9 falls
    {6'h00, 1'b0, 6'h3F, 1'b0, 8'h00, 1'b0}, // 5
    {6'h3C, 1'b0, 6'h3F, 1'b0, 8'h00, 1'b0}, // 6  bits 2..5 rise
    {6'h3C, 1'b0, 6'h3F, 1'b1, 8'h3C, 1'b1}, // 7  R1 positions, R3 read
    {6'h00, 1'b0, 6'h3F, 1'b0, 8'h00, 1'b0}, // 8  R3 cleared
    {6'h02, 1'b0, 6'h3F, 1'b1, 8'h00, 1'b0}, // 9  R7 onset with read
    {6'h02, 1'b0, 6'h3F, 1'b0, 8'h02, 1'b1}, // 10 R7 onset survived
    {6'h02, 1'b0, 6'h3D, 1'b0, 8'h02, 1'b1}, // 11 disable AIS
    {6'h02, 1'b0, 6'h3D, 1'b0, 8'h02, 1'b0}, // 12 R9 masked
    {6'h02, 1'b0, 6'h3F, 1'b0, 8'h02, 1'b0}, // 13 R5 enable rise
    {6'h00, 1'b0, 6'h3F, 1'b0, 8'h00, 1'b0}, // 14 R5 wiped
    {6'h00, 1'b1, 6'h3F, 1'b0, 8'h00, 1'b0}, // 15 E3
    {6'h38, 1'b1, 6'h3F, 1'b0, 8'h00, 1'b0}, // 16 SEF idle LOS rise in E3
    {6'h38, 1'b1, 6'h3F, 1'b1, 8'h10, 1'b1}, // 17 R6 only LOS
    {6'h00, 1'b0, 6'h3F, 1'b0, 8'h00, 1'b0}, // 18
    {6'h00, 1'b0, 6'h3E, 1'b0, 8'h00, 1'b0}, // 19
    {6'h01, 1'b0, 6'h3E, 1'b0, 8'h00, 1'b0}, // 20 OOF rises disabled
    {6'h00, 1'b0, 6'h3E, 1'b0, 8'h01, 1'b0}, // 21 R9 no request
    {6'h01, 1'b0, 6'h3F, 1'b0, 8'h01, 1'b0}, // 22 R8 onset with enable rise
    {6'h01, 1'b0, 6'h3F, 1'b0, 8'h01, 1'b1}  // 23 R8 bit kept, request up
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] alarmLvl = '0;
  logic       e3Mode = 1'b0;
  logic [5:0] evtEnable = '0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_onset_status u0 (
    .clk(clk), .rstN(rstN), .alarmLvl(alarmLvl), .e3Mode(e3Mode),
    .evtEnable(evtEnable), .rdStrobe(rdStrobe), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R2 reset rdData", rdData, 8'h00);
    chk("R2 reset irq", {7'b0, irq}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      {alarmLvl, e3Mode, evtEnable, rdStrobe} = VEC[r][22:9];
      #1;
      chk($sformatf("R1 R3-R9 row %0d rdData", r), rdData, VEC[r][8:1]);
      chk($sformatf("R9 row %0d irq", r), {7'b0, irq}, {7'b0, VEC[r][0]});
      @(negedge clk);
    end
    // R1: reserved bits stay zero with all alarms active
    alarmLvl = 6'h00; rdStrobe = 1'b0; evtEnable = 6'h3F;
    @(negedge clk);
    alarmLvl = 6'h3F;
    @(negedge clk);
    #1;
    chk("R1 all bits, reserved zero", rdData, 8'h3F);
    chk("R9 irq with all set", {7'b0, irq}, 8'h01);
    // R2: reset while latched
    rstN = 1'b0;
    @(negedge clk);
    #1;
    chk("R2 reset clears rdData", rdData, 8'h00);
    chk("R2 reset clears irq", {7'b0, irq}, 8'h00);
    rstN = 1'b1;
    alarmLvl = 6'h00;
    @(negedge clk);
    // R6: E3 read after SEF alone shows nothing
    e3Mode = 1'b1;
    alarmLvl = 6'h20;
    @(negedge clk);
    #1;
    chk("R6 SEF in E3", rdData, 8'h00);
    chk("R6 irq in E3", {7'b0, irq}, 8'h00);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule